// File: doc/BRIEF.md
# Configurable Oversampling Interpolation Chain

This block takes PCM audio samples at the base rate and raises them to the rate of a following noise-shaping modulator. A word-length stage first places 16-, 18-, 20- or 24-bit words into a common 24-bit frame. Three two-times halfband interpolators follow in cascade, and a three-stage CIC interpolator comes last. The CIC rate change can be selected, so the total oversampling is 32, 64 or 128. The halfband filters use fixed canonical-signed-digit weights, so every tap is a shift and an add and the chain has no multipliers.

The block runs on the modulator clock, which is the oversampling ratio times the base sample rate. Input samples must arrive exactly one ratio period apart. Once the first result reaches the output, the block delivers one rounded, saturated 24-bit sample on every clock. The ratio and the word-length selects are static settings and may change only while the block is held in reset.

Top module: `oversample_chain`

## Requirements
- R1: While reset is asserted, and afterwards until the first input sample has been accepted, `sample_o` is zero and `sample_valid_o` is low.
- R2: The word-length code selects 16 (code 0), 18 (code 1), 20 (code 2) or 24 (code 3) bits. The word sits in `sample_i[L-1:0]` with its sign at bit L-1. Bits above L-1 are ignored. The word is shifted left by 24-L, and the low bits are filled with zeros.
- R3: The ratio code selects a total oversampling of 32 (code 0), 64 (code 1) or 128 (codes 2 and 3). This total is eight times the CIC rate change of 4, 8 or 16. Inputs are presented exactly one total-ratio period of clocks apart.
- R4: After the first result appears, `sample_valid_o` stays high on every clock, giving one output per clock and therefore ratio-many outputs per input.
- R5: A constant input held long enough gives an output equal to the aligned input value exactly, at every ratio and word length.
- R6: Each halfband stage doubles the rate. Even outputs repeat the centre sample. Odd outputs are formed with weights -1, 9, 9, -1 over 16, built from shifts and adds, so a rising step shows a small negative pre-ring before the rise.
- R7: Results outside the 24-bit signed range are clipped to 0x7FFFFF or 0x800000 and never wrap around.
- R8: The CIC stage removes its gain of the rate change squared by a rounded arithmetic right shift chosen from the ratio code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 24 | Input word, right-justified, two's complement |
| sample_valid_i | input | 1 | One-cycle strobe per base-rate sample |
| wlen_sel_i | input | 2 | Word-length code (R2) |
| ratio_sel_i | input | 2 | Oversampling code (R3) |
| sample_o | output | 24 | Interpolated, rounded, saturated sample |
| sample_valid_o | output | 1 | Output strobe, high each clock once running |

## Verification
The chain is driven with constant levels at each ratio code, including code 3 and both full-scale extremes. An error in the normalising shift or in the stage cadence shows up as a wrong steady value or as gaps in the output strobe. The same constant-level checks use 16-, 18- and 20-bit words with junk in the unused upper bits, which separates correct alignment and sign handling from plain truncation. A step from zero to near full scale at the highest ratio exposes the halfband pre-ring and the clipping of the overshoot, and it would show any sign wrap in the output stage.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int unsigned SAMPLE_W    = 24;
  localparam int unsigned CIC_LOG2_LO = 2;
  localparam int unsigned CIC_LOG2_HI = 4;

  typedef enum logic [1:0] {
    WL_16 = 2'd0,
    WL_18 = 2'd1,
    WL_20 = 2'd2,
    WL_24 = 2'd3
  } wlen_e;

  // log2 of the CIC rate change; codes 2 and 3 both give the highest ratio
  function automatic logic [2:0] cic_log2(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'(CIC_LOG2_LO);
      2'd1:    return 3'(CIC_LOG2_LO + 1);
      default: return 3'(CIC_LOG2_HI);
    endcase
  endfunction
endpackage

// File: rtl/osc_align.sv
module osc_align
  import osc_pkg::*;
#(
  parameter int unsigned SW = SAMPLE_W
) (
  input  logic [SW-1:0] raw_i,
  input  logic [1:0]    wlen_sel_i,
  output logic [SW-1:0] aligned_o
);
  int unsigned shamt;

  always_comb begin
    case (wlen_e'(wlen_sel_i))
      WL_16:   shamt = SW - 16;
      WL_18:   shamt = SW - 18;
      WL_20:   shamt = SW - 20;
      default: shamt = 0;
    endcase
    // bits above the word fall off the top
    aligned_o = raw_i << shamt;
  end
endmodule

// File: rtl/osc_halfband.sv
module osc_halfband #(
  parameter int unsigned W     = 26,
  parameter int unsigned CNT_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    half_i,
  input  logic signed [W-1:0] in_i,
  input  logic                in_valid_i,
  output logic signed [W-1:0] out_o,
  output logic                out_valid_o
);
  localparam int unsigned TAPS = 4;
  localparam int unsigned AW   = W + 5;

  logic signed [W-1:0]  tap_q [TAPS];
  logic [CNT_W-1:0]     cnt_q;
  logic signed [AW-1:0] inner, outer, acc;
  logic signed [W-1:0]  mid;

  // odd phase: (9*(inner pair) - (outer pair) + 8) / 16, 9 = 8 + 1
  always_comb begin
    inner = AW'(tap_q[1]) + AW'(tap_q[2]);
    outer = AW'(tap_q[0]) + AW'(tap_q[3]);
    acc   = (inner <<< 3) + inner - outer + AW'(8);
    mid   = W'(acc >>> 4);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS; k++) tap_q[k] <= '0;
      cnt_q       <= '0;
      out_o       <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      if (in_valid_i) begin
        tap_q[0] <= in_i;
        for (int k = 1; k < TAPS; k++) tap_q[k] <= tap_q[k-1];
        cnt_q <= CNT_W'(1);
      end else if (cnt_q != '0 && cnt_q != '1) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (cnt_q == CNT_W'(1)) begin
        out_o       <= tap_q[2];
        out_valid_o <= 1'b1;
      end else if (cnt_q == half_i + CNT_W'(1)) begin
        out_o       <= mid;
        out_valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/osc_cic.sv
module osc_cic #(
  parameter int unsigned W_IN  = 26,
  parameter int unsigned N     = 3,
  parameter int unsigned W_ACC = 38,
  parameter int unsigned OUT_W = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             log2r_i,
  input  logic signed [W_IN-1:0] in_i,
  input  logic                   in_valid_i,
  output logic [OUT_W-1:0]       out_o,
  output logic                   out_valid_o
);
  localparam logic signed [W_ACC-1:0] SAT_HI =
    W_ACC'((longint'(1) <<< (OUT_W - 1)) - 1);
  localparam logic signed [W_ACC-1:0] SAT_LO = ~SAT_HI;

  logic signed [W_ACC-1:0] comb_d [N+1];
  logic signed [W_ACC-1:0] comb_q [N];
  logic signed [W_ACC-1:0] integ_q [N];
  logic signed [W_ACC-1:0] feed_q, rnd, scaled, sat;
  logic                    started_q;
  int unsigned             sh;

  always_comb begin
    comb_d[0] = {{(W_ACC - W_IN){in_i[W_IN-1]}}, in_i};
    for (int k = 0; k < N; k++) comb_d[k+1] = comb_d[k] - comb_q[k];
  end

  // gain R^(N-1) is a power of two: rounded shift
  always_comb begin
    sh     = (N - 1) * int'(log2r_i);
    rnd    = W_ACC'(1) << (sh - 1);
    scaled = (integ_q[N-1] + rnd) >>> sh;
    if (scaled > SAT_HI)      sat = SAT_HI;
    else if (scaled < SAT_LO) sat = SAT_LO;
    else                      sat = scaled;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) begin
        comb_q[k]  <= '0;
        integ_q[k] <= '0;
      end
      feed_q      <= '0;
      started_q   <= 1'b0;
      out_o       <= '0;
      out_valid_o <= 1'b0;
    end else begin
      if (in_valid_i)
        for (int k = 0; k < N; k++) comb_q[k] <= comb_d[k];
      feed_q    <= in_valid_i ? comb_d[N] : '0;
      started_q <= started_q | in_valid_i;
      for (int k = 0; k < N; k++)
        integ_q[k] <= integ_q[k] + ((k == 0) ? feed_q : integ_q[k-1]);
      out_o       <= OUT_W'(sat);
      out_valid_o <= started_q;
    end
  end
endmodule

// File: rtl/oversample_chain.sv
module oversample_chain
  import osc_pkg::*;
#(
  parameter int unsigned SW         = SAMPLE_W,
  parameter int unsigned GUARD_W    = 2,
  parameter int unsigned HB_STAGES  = 3,
  parameter int unsigned CIC_N      = 3,
  parameter int unsigned CNT_W      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sample_i,
  input  logic          sample_valid_i,
  input  logic [1:0]    wlen_sel_i,
  input  logic [1:0]    ratio_sel_i,
  output logic [SW-1:0] sample_o,
  output logic          sample_valid_o
);
  localparam int unsigned HW    = SW + GUARD_W;
  localparam int unsigned W_ACC = HW + CIC_N * CIC_LOG2_HI;

  logic [SW-1:0]       aligned;
  logic [2:0]          log2r;
  logic signed [HW-1:0] hb_data  [HB_STAGES+1];
  logic                 hb_valid [HB_STAGES+1];
  logic [CNT_W-1:0]     hb_half  [HB_STAGES];

  osc_align #(.SW(SW)) u_align (
    .raw_i      (sample_i),
    .wlen_sel_i (wlen_sel_i),
    .aligned_o  (aligned)
  );

  assign log2r       = cic_log2(ratio_sel_i);
  assign hb_data[0]  = {{GUARD_W{aligned[SW-1]}}, aligned};
  assign hb_valid[0] = sample_valid_i;

  for (genvar k = 0; k < HB_STAGES; k++) begin : g_hb
    // output spacing of stage k: CIC rate times 2^(remaining stages)
    assign hb_half[k] = CNT_W'(1) << (int'(log2r) + HB_STAGES - 1 - k);
    osc_halfband #(.W(HW), .CNT_W(CNT_W)) u_hb (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .half_i      (hb_half[k]),
      .in_i        (hb_data[k]),
      .in_valid_i  (hb_valid[k]),
      .out_o       (hb_data[k+1]),
      .out_valid_o (hb_valid[k+1])
    );
  end

  osc_cic #(.W_IN(HW), .N(CIC_N), .W_ACC(W_ACC), .OUT_W(SW)) u_cic (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .log2r_i     (log2r),
    .in_i        (hb_data[HB_STAGES]),
    .in_valid_i  (hb_valid[HB_STAGES]),
    .out_o       (sample_o),
    .out_valid_o (sample_valid_o)
  );
endmodule

// File: rtl/oversample_chain_chk.sv
module oversample_chain_chk #(
  parameter int unsigned SW      = 24,
  parameter int unsigned SETTLE  = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [SW-1:0] sample_i,
  input logic          sample_valid_i,
  input logic [1:0]    wlen_sel_i,
  input logic [SW-1:0] sample_o,
  input logic          sample_valid_o
);
  logic          seen_q;
  logic [SW-1:0] last_q, exp_q, exp_d;
  int unsigned   same_q, shamt;

  always_comb begin
    case (wlen_sel_i)
      2'd0:    shamt = SW - 16;
      2'd1:    shamt = SW - 18;
      2'd2:    shamt = SW - 20;
      default: shamt = 0;
    endcase
    exp_d = sample_i << shamt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
      exp_q  <= '0;
      same_q <= 0;
    end else if (sample_valid_i) begin
      seen_q <= 1'b1;
      last_q <= sample_i;
      exp_q  <= exp_d;
      if (sample_i != last_q)  same_q <= 1;
      else if (same_q < SETTLE) same_q <= same_q + 1;
    end
  end

  a_r1_quiet_before_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!sample_valid_o && sample_o == '0));

  a_r4_output_every_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> sample_valid_o);

  a_r5_dc_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_q >= SETTLE && sample_valid_o) |-> sample_o == exp_q);

  a_r7_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_o && $past(sample_valid_o) &&
     $signed($past(sample_o)) > $signed(24'h600000)) |-> $signed(sample_o) > 0);
endmodule

bind oversample_chain oversample_chain_chk #(.SW(SW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_i       (sample_i),
  .sample_valid_i (sample_valid_i),
  .wlen_sel_i     (wlen_sel_i),
  .sample_o       (sample_o),
  .sample_valid_o (sample_valid_o)
);

// File: tb/oversample_chain_bench.sv
module oversample_chain_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] sample_i = '0;
  logic        sample_valid_i = 1'b0;
  logic [1:0]  wlen_sel_i = 2'd3;
  logic [1:0]  ratio_sel_i = 2'd2;
  logic [23:0] sample_o;
  logic        sample_valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  oversample_chain u_oversample_chain (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .sample_i       (sample_i),
    .sample_valid_i (sample_valid_i),
    .wlen_sel_i     (wlen_sel_i),
    .ratio_sel_i    (ratio_sel_i),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o)
  );

  // {wlen, ratio, input word, expected steady output}
  localparam int NV = 9;
  localparam logic [51:0] VECS [NV] = '{
    {2'd3, 2'd2, 24'h123456, 24'h123456},
    {2'd3, 2'd0, 24'hCBA988, 24'hCBA988},
    {2'd3, 2'd1, 24'h7FFFFF, 24'h7FFFFF},
    {2'd0, 2'd2, 24'h00ABCD, 24'hABCD00},
    {2'd1, 2'd1, 24'hFD2345, 24'h48D140},
    {2'd2, 2'd0, 24'hA80001, 24'h800010},
    {2'd3, 2'd3, 24'h000100, 24'h000100},
    {2'd0, 2'd0, 24'hFF8000, 24'h800000},
    {2'd2, 2'd2, 24'h0FFFFF, 24'hFFFFF0}
  };

  // output monitor
  bit          mon_en = 0;
  int          mon_valid, mon_bad, mon_max, mon_min, mon_wrap;
  bit          mon_hi;
  logic [23:0] mon_exp, mon_first;

  always @(negedge clk) begin
    if (mon_en && sample_valid_o) begin
      int s;
      s = $signed(sample_o);
      mon_valid++;
      if (sample_o != mon_exp) begin
        if (mon_bad == 0) mon_first = sample_o;
        mon_bad++;
      end
      if (s > mon_max) mon_max = s;
      if (s < mon_min) mon_min = s;
      if (s > 32'sh400000) mon_hi = 1;
      if (mon_hi && s < 0) mon_wrap++;
    end
  end

  task automatic mon_clear(input logic [23:0] e);
    mon_valid = 0; mon_bad = 0; mon_wrap = 0; mon_hi = 0;
    mon_max = -(1 << 30); mon_min = 1 << 30;
    mon_exp = e; mon_first = e;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int period(input logic [1:0] r);
    case (r)
      2'd0:    return 32;
      2'd1:    return 64;
      default: return 128;
    endcase
  endfunction

  task automatic do_reset(input logic [1:0] wl, input logic [1:0] r);
    @(negedge clk);
    rst_ni = 1'b0; sample_valid_i = 1'b0; sample_i = '0;
    wlen_sel_i = wl; ratio_sel_i = r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic feed(input logic [23:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_i = d; sample_valid_i = 1'b1;
      @(negedge clk);
      sample_valid_i = 1'b0;
      repeat (period(ratio_sel_i) - 2) @(negedge clk);
    end
  endtask

  task automatic watch(input logic [23:0] d, input int n, input logic [23:0] e);
    @(posedge clk);
    mon_clear(e);
    mon_en = 1;
    feed(d, n);
    @(posedge clk);
    mon_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state and quiet until the first input
    repeat (2) @(negedge clk);
    check(sample_o == '0, "R1 reset data", int'(sample_o), 0);
    check(sample_valid_o == 1'b0, "R1 reset valid", int'(sample_valid_o), 0);
    rst_ni = 1'b1;
    begin
      int vcount = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (sample_valid_o || sample_o != '0) vcount++;
      end
      check(vcount == 0, "R1 idle without input", vcount, 0);
    end

    // R2 R3 R5 R8 steady values, R4 output cadence
    for (int v = 0; v < NV; v++) begin
      logic [51:0] t;
      t = VECS[v];
      do_reset(t[51:50], t[49:48]);
      feed(t[47:24], 30);
      watch(t[47:24], 4, t[23:0]);
      check(mon_bad == 0, $sformatf("R5 R2 R3 R8 dc vector %0d", v),
            int'(mon_first), int'(t[23:0]));
      check(mon_valid == 4 * period(t[49:48]), $sformatf("R4 output count vector %0d", v),
            mon_valid, 4 * period(t[49:48]));
    end

    // R6 pre-ring, R7 clipping on a near full-scale step
    do_reset(2'd3, 2'd2);
    feed(24'h000000, 10);
    watch(24'h7F0000, 20, 24'h7F0000);
    check(mon_max == 32'sh7FFFFF, "R7 overshoot clipped", mon_max, 32'h7FFFFF);
    check(mon_wrap == 0, "R7 no wrap", mon_wrap, 0);
    check(mon_min < 0, "R6 pre-ring below zero", mon_min, -1);
    check(mon_min > -32'sh100000, "R6 pre-ring small", mon_min, -32'sh100000);
    watch(24'h7F0000, 4, 24'h7F0000);
    check(mon_bad == 0, "R5 settled after step", int'(mon_first), 32'h7F0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule